// File: doc/BRIEF.md
# Soft-Start Loop Filter Handover Controller

This block decides which coefficient set the voltage-loop compensator uses while the converter output starts up. After reset, and after every soft-start request, it selects the dedicated soft-start filter and raises a status flag. It also passes the programmed soft-start gain code to the filter datapath. The soft-start filter stays selected for the whole reference ramp. Once the ramp has finished, the block waits until the fast output-sense converter has reported a settled reading without a break for a programmable debounce time. Only then does it hand the loop over to the normal filter.

The debounce time is counted in ticks of an external 1 ms strobe, so the counter width does not depend on the system clock frequency. One configuration bit selects a short debounce (5 ms by default) or a long one (10 ms by default). The handover is final. Only a new soft-start request or a reset brings the soft-start filter back.

Top module: `ss_handover`

## Requirements
- R1: While `rst` is high and at the first clock edge after it, `filt_sel` is 0 and `ss_flag` is 1. `ss_gain` is 0 while `rst` is high.
- R2: While the soft-start filter is selected (`filt_sel`=0), `ss_gain` equals `cfg_ss_gain`, one clock later. While the normal filter is selected (`filt_sel`=1), `ss_gain` is 0.
- R3: While `ramp_done` is 0, no number of ticks, with or without `adc_settled`, causes a handover.
- R4: With `cfg_dbnc_long`=0, `filt_sel` goes to 1 once `ramp_done` and `adc_settled` have both been high through 5 consecutive `ms_tick` pulses. It does not do so after 4 pulses. It changes at the second rising edge after the edge that samples the fifth tick.
- R5: With `cfg_dbnc_long`=1, the handover needs 10 such ticks and does not happen after 9.
- R6: Any clock edge that samples `adc_settled`=0 restarts the debounce count from zero.
- R7: Once the normal filter is selected, low `adc_settled`, low `ramp_done` and further ticks have no effect on the outputs.
- R8: An `ss_start` pulse returns the outputs to soft-start selection at the next rising edge after the edge that samples it. It also clears the debounce count, and it takes priority over a handover in the same cycle.
- R9: `ss_flag` is always the complement of `filt_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ss_start | input | 1 | Soft-start request pulse |
| ramp_done | input | 1 | Reference ramp has reached its target |
| adc_settled | input | 1 | Fast output-sense converter reports a settled reading |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| cfg_ss_gain | input | 2 | Soft-start filter gain code |
| cfg_dbnc_long | input | 1 | 0 selects the short debounce, 1 the long one |
| filt_sel | output | 1 | 0 selects the soft-start filter, 1 the normal loop filter |
| ss_gain | output | 2 | Gain code for the soft-start filter, 0 in normal mode |
| ss_flag | output | 1 | High while the soft-start filter is in use |

## Verification
The handover lands at the second rising edge after the edge that samples the final qualifying tick: one edge for the counter, one for the state and one for the output register. A soft-start request shows at the edge that follows the one sampling it. After each stimulus, the driver waits exactly that number of rising edges before it queues the expected value. The monitor compares it at the next falling edge. This exact timing is what catches an early handover after one tick too few, as well as a late one. The tick counts one short of the limit are checked with the same alignment.

// File: rtl/ssho_pkg.sv
package ssho_pkg;
  typedef enum logic [0:0] {
    ST_SOFT = 1'b0,
    ST_NORM = 1'b1
  } ssho_state_t;
endpackage

// File: rtl/ssho_debounce.sv
module ssho_debounce #(
  parameter int SHORT_MS = 5,
  parameter int LONG_MS  = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic qualify,
  input  logic tick,
  input  logic long_sel,
  output logic done
);
  localparam int CNT_W = $clog2(LONG_MS + 1);
  localparam logic [CNT_W-1:0] LIM_S = CNT_W'(SHORT_MS);
  localparam logic [CNT_W-1:0] LIM_L = CNT_W'(LONG_MS);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = long_sel ? LIM_L : LIM_S;
  assign done  = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || clear || !qualify) begin
      cnt <= '0;
    end else if (tick && (cnt < limit)) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM_L);

  // R6
  done_by_tick_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(done) && $stable(long_sel)) |-> $past(tick));
endmodule

// File: rtl/ssho_seq.sv
module ssho_seq
  import ssho_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic done,
  output logic in_norm
);
  ssho_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    if (clear) begin
      state_nx = ST_SOFT;
    end else if ((state == ST_SOFT) && done) begin
      state_nx = ST_NORM;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_SOFT;
    else     state <= state_nx;
  end

  assign in_norm = (state == ST_NORM);

  // R4
  handover_gated_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(in_norm) |-> $past(done));

  // R8
  start_returns_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> !in_norm);
endmodule

// File: rtl/ssho_outreg.sv
module ssho_outreg #(
  parameter int GAIN_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_norm,
  input  logic [GAIN_W-1:0] cfg_gain,
  output logic              sel_q,
  output logic              flag_q,
  output logic [GAIN_W-1:0] gain_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      flag_q <= 1'b1;
      gain_q <= '0;
    end else begin
      sel_q  <= in_norm;
      flag_q <= !in_norm;
      gain_q <= in_norm ? '0 : cfg_gain;
    end
  end

  // R2
  gain_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    sel_q |-> (gain_q == '0));

  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    flag_q != sel_q);

  // R7
  sel_follows_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_q) |-> $past(in_norm));
endmodule

// File: rtl/ss_handover.sv
module ss_handover #(
  parameter int SHORT_MS = 5,
  parameter int LONG_MS  = 10,
  parameter int GAIN_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ss_start,
  input  logic              ramp_done,
  input  logic              adc_settled,
  input  logic              ms_tick,
  input  logic [GAIN_W-1:0] cfg_ss_gain,
  input  logic              cfg_dbnc_long,
  output logic              filt_sel,
  output logic [GAIN_W-1:0] ss_gain,
  output logic              ss_flag
);
  logic qualify;
  logic dbnc_done;
  logic in_norm;

  assign qualify = ramp_done & adc_settled;

  ssho_debounce #(
    .SHORT_MS(SHORT_MS),
    .LONG_MS (LONG_MS)
  ) u_dbnc (
    .clk     (clk),
    .rst     (rst),
    .clear   (ss_start),
    .qualify (qualify),
    .tick    (ms_tick),
    .long_sel(cfg_dbnc_long),
    .done    (dbnc_done)
  );

  ssho_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .clear  (ss_start),
    .done   (dbnc_done),
    .in_norm(in_norm)
  );

  ssho_outreg #(
    .GAIN_W(GAIN_W)
  ) u_out (
    .clk     (clk),
    .rst     (rst),
    .in_norm (in_norm),
    .cfg_gain(cfg_ss_gain),
    .sel_q   (filt_sel),
    .flag_q  (ss_flag),
    .gain_q  (ss_gain)
  );

  // R3
  no_early_handover_chk: assert property (@(posedge clk) disable iff (rst)
    (!ramp_done && !filt_sel && !in_norm && !dbnc_done) |=> !in_norm);
endmodule

// File: tb/sim_ss_handover.sv
module sim_ss_handover;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ss_start = 1'b0;
  logic       ramp_done = 1'b0;
  logic       adc_settled = 1'b0;
  logic       ms_tick = 1'b0;
  logic [1:0] cfg_ss_gain = 2'b10;
  logic       cfg_dbnc_long = 1'b0;
  logic       filt_sel;
  logic [1:0] ss_gain;
  logic       ss_flag;

  int n_chk  = 0;
  int n_fail = 0;
  bit all_done = 1'b0;

  typedef struct {
    logic       sel;
    logic [1:0] gain;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  always #5 clk = ~clk;

  ss_handover u0 (
    .clk          (clk),
    .rst          (rst),
    .ss_start     (ss_start),
    .ramp_done    (ramp_done),
    .adc_settled  (adc_settled),
    .ms_tick      (ms_tick),
    .cfg_ss_gain  (cfg_ss_gain),
    .cfg_dbnc_long(cfg_dbnc_long),
    .filt_sel     (filt_sel),
    .ss_gain      (ss_gain),
    .ss_flag      (ss_flag)
  );

  task automatic expect_out(input logic sel, input logic [1:0] gain, input string tag);
    exp_t e;
    e.sel = sel; e.gain = gain; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic expect_now(input logic sel, input string tag);
    expect_out(sel, sel ? 2'b00 : cfg_ss_gain, tag);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic give_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
    end
  endtask

  task automatic settle_edges();
    @(posedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_start();
    @(negedge clk) ss_start = 1'b1;
    @(negedge clk) ss_start = 1'b0;
    @(posedge clk);
    #1;
  endtask

  // monitor: pops expected items at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_chk++;
        if (filt_sel !== e.sel || ss_gain !== e.gain) begin
          n_fail++;
          $display("FAIL %s: sel=%0b gain=%0d expected sel=%0b gain=%0d",
                   e.tag, filt_sel, ss_gain, e.sel, e.gain);
        end
        n_chk++;
        if (ss_flag !== !e.sel) begin
          n_fail++;
          $display("FAIL R9 (%s): flag=%0b expected %0b", e.tag, ss_flag, !e.sel);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!all_done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    expect_out(1'b0, 2'b00, "R1 in reset");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    expect_out(1'b0, 2'b10, "R1 after reset");
    @(negedge clk);

    // R3 ramp not done: no handover
    adc_settled = 1'b1;
    give_ticks(12);
    settle_edges();
    expect_now(1'b0, "R3 ramp pending");

    // R4 short debounce: 4 ticks not enough, 5th hands over
    ramp_done = 1'b1;
    give_ticks(4);
    settle_edges();
    expect_now(1'b0, "R4 four ticks");
    give_ticks(1);
    settle_edges();
    expect_out(1'b1, 2'b00, "R4 fifth tick / R2 gain zero");
    @(negedge clk);

    // R7 sticky handover
    adc_settled = 1'b0;
    ramp_done = 1'b0;
    give_ticks(3);
    settle_edges();
    expect_now(1'b1, "R7 normal kept");

    // R8 start returns to soft start
    pulse_start();
    expect_out(1'b0, 2'b10, "R8 start");
    @(negedge clk);

    // R2 gain follows config in soft start
    cfg_ss_gain = 2'b01;
    @(posedge clk);
    #1;
    expect_out(1'b0, 2'b01, "R2 gain update");
    @(negedge clk);

    // R5 long debounce
    cfg_dbnc_long = 1'b1;
    ramp_done = 1'b1;
    adc_settled = 1'b1;
    give_ticks(9);
    settle_edges();
    expect_now(1'b0, "R5 nine ticks");
    give_ticks(1);
    settle_edges();
    expect_now(1'b1, "R5 tenth tick");

    // R6 unsettled sample restarts count
    cfg_dbnc_long = 1'b0;
    pulse_start();
    expect_now(1'b0, "R8 restart");
    give_ticks(3);
    @(negedge clk) adc_settled = 1'b0;
    @(negedge clk) adc_settled = 1'b1;
    give_ticks(4);
    settle_edges();
    expect_now(1'b0, "R6 count restarted");
    give_ticks(1);
    settle_edges();
    expect_now(1'b1, "R6 full window after restart");

    // R8 start clears the debounce count
    pulse_start();
    give_ticks(4);
    pulse_start();
    give_ticks(4);
    settle_edges();
    expect_now(1'b0, "R8 count cleared");
    give_ticks(1);
    settle_edges();
    expect_now(1'b1, "R8 handover after clear");

    repeat (3) @(negedge clk);
    all_done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule